// File: doc/BRIEF.md
# Clock glitch insertion controller

This block builds the clock used in fault-injection experiments. A source clock and a narrow glitch pulse enter the block; the pulse is already placed in phase by logic outside. The block decides when glitching is live and, while it is live, combines the two waveforms in one of several ways. The result drives the clock pin of the device under attack. Phase generation, the choice of clock source and the host register access are all outside this block.

A burst of glitching can be started in four ways: by a manual strobe, by each rising edge of an external capture trigger, by a single armed capture trigger, or by free-running operation. The length of a burst is programmed as the cycle count minus one. The counter width is a parameter, so a burst can run past 256 cycles. A busy output follows the internal glitch-live flag, so glitched cycles can be counted at the ports.

Top module: `gins_top`

## Requirements
- R1: While `rstN` is low and on the first cycles after it, `busy` is 0 and with `glitchType` = 000 the output `glitchClk` equals `srcClk`.
- R2: With `trigMode` = 00 (manual), a 0-to-1 change of `manualStrobe` seen at a rising `srcClk` edge sets `busy` from that edge; holding the strobe high does not start another burst.
- R3: A burst started with `repeatCount` = N keeps `busy` high for exactly N+1 source-clock cycles. With the default counter width of 10 bits, N may exceed 255 (N = 300 gives 301 cycles).
- R4: With `trigMode` = 01 (capture), each 0-to-1 change of `capTrig` starts a burst; a `capTrig` level held high starts only one burst.
- R5: With `trigMode` = 11 (single shot), a capture edge starts a burst only if `manualStrobe` has risen and is still 1. After one burst, further capture edges are ignored until the strobe goes to 0 and rises again.
- R6: With `trigMode` = 10 (continuous), `busy` is 1 on every cycle after the first edge in that mode, whatever `repeatCount` holds.
- R7: With `glitchType` 000, 001 and 010, `glitchClk` is `srcClk ^ glitchPulse`, `srcClk | glitchPulse` and `glitchPulse` respectively while `busy` is 1, and equals `srcClk` while `busy` is 0.
- R8: With `glitchType` = 011, or any code from 101 to 111, `glitchClk` equals `srcClk`; with `glitchType` = 100, `glitchClk` equals `busy`.
- R9: A new trigger that arrives during a burst restarts the cycle count, so the burst ends N+1 cycles after the new trigger.
- R10: In manual mode the capture trigger has no effect, and in capture mode the manual strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source clock; also the control clock |
| rstN | input | 1 | Asynchronous reset, active low |
| capTrig | input | 1 | External capture trigger (edge-detected) |
| glitchPulse | input | 1 | Phase-derived glitch pulse |
| trigMode | input | 2 | Trigger source: 00 manual, 01 capture, 10 continuous, 11 single shot |
| glitchType | input | 3 | Output combination select |
| manualStrobe | input | 1 | Manual request / single-shot arm bit |
| repeatCount | input | CNT_W | Glitched cycles minus one |
| glitchClk | output | 1 | Glitched clock output |
| busy | output | 1 | Glitching is live |

## Verification
The hardest state to reach is the single-shot mode after one burst has been spent, because it depends on the order of three events: the strobe rising, a capture edge, and the strobe falling and rising again. The stimulus walks through this order on purpose. It sends a capture edge before arming, sends two edges after one arming, and then re-arms. The same run also sends a retrigger partway through a burst and a burst longer than 256 cycles. These show the restart of the count and a count wider than one byte.

// File: rtl/gins_pkg.sv
package gins_pkg;

  typedef enum logic [1:0] {
    TRIG_MANUAL  = 2'b00,
    TRIG_CAPTURE = 2'b01,
    TRIG_FREE    = 2'b10,
    TRIG_ONESHOT = 2'b11
  } trigMode_e;

  typedef enum logic [2:0] {
    MIX_XOR   = 3'b000,
    MIX_OR    = 3'b001,
    MIX_PULSE = 3'b010,
    MIX_CLOCK = 3'b011,
    MIX_LEVEL = 3'b100
  } mixType_e;

  typedef struct packed {
    logic glitchOn;
  } ctlStrobes_t;

endpackage

// File: rtl/gins_control.sv
module gins_control
  import gins_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capTrig,
  input  logic             manualStrobe,
  input  logic [1:0]       trigMode,
  input  logic [CNT_W-1:0] repeatCount,
  output ctlStrobes_t      strobes
);

  trigMode_e        mode;
  logic             capPrev;
  logic             strobePrev;
  logic             armed;
  logic             active;
  logic [CNT_W-1:0] count;
  logic             capRise;
  logic             strobeRise;
  logic             startBurst;
  logic             oneShotFire;
  logic             freeRun;

  assign mode       = trigMode_e'(trigMode);
  assign capRise    = capTrig & ~capPrev;
  assign strobeRise = manualStrobe & ~strobePrev;
  assign oneShotFire = (mode == TRIG_ONESHOT) & capRise & armed & manualStrobe;
  assign freeRun    = (mode == TRIG_FREE);

  always_comb begin
    unique case (mode)
      TRIG_MANUAL:  startBurst = strobeRise;
      TRIG_CAPTURE: startBurst = capRise;
      TRIG_ONESHOT: startBurst = oneShotFire;
      default:      startBurst = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capPrev    <= 1'b0;
      strobePrev <= 1'b0;
    end else begin
      capPrev    <= capTrig;
      strobePrev <= manualStrobe;
    end
  end

  // single-shot arming: set by a strobe rise, spent by one burst or a low strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (strobeRise) begin
      armed <= 1'b1;
    end else if (!manualStrobe || oneShotFire) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      count  <= '0;
    end else if (startBurst) begin
      active <= 1'b1;
      count  <= '0;
    end else if (freeRun) begin
      active <= 1'b1;
    end else if (active) begin
      if (count >= repeatCount) begin
        active <= 1'b0;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  assign strobes.glitchOn = active;

endmodule

// File: rtl/gins_datapath.sv
module gins_datapath
  import gins_pkg::*;
(
  input  logic        srcClk,
  input  logic        glitchPulse,
  input  logic [2:0]  glitchType,
  input  ctlStrobes_t strobes,
  output logic        glitchClk
);

  mixType_e mix;
  logic     gatedPulse;

  assign mix        = mixType_e'(glitchType);
  assign gatedPulse = glitchPulse & strobes.glitchOn;

  always_comb begin
    case (mix)
      MIX_XOR:   glitchClk = srcClk ^ gatedPulse;
      MIX_OR:    glitchClk = srcClk | gatedPulse;
      MIX_PULSE: glitchClk = strobes.glitchOn ? glitchPulse : srcClk;
      MIX_LEVEL: glitchClk = strobes.glitchOn;
      default:   glitchClk = srcClk;
    endcase
  end

endmodule

// File: rtl/gins_top.sv
module gins_top
  import gins_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             srcClk,
  input  logic             rstN,
  input  logic             capTrig,
  input  logic             glitchPulse,
  input  logic [1:0]       trigMode,
  input  logic [2:0]       glitchType,
  input  logic             manualStrobe,
  input  logic [CNT_W-1:0] repeatCount,
  output logic             glitchClk,
  output logic             busy
);

  ctlStrobes_t strobes;

  gins_control #(.CNT_W(CNT_W)) ctl_i (
    .clk          (srcClk),
    .rstN         (rstN),
    .capTrig      (capTrig),
    .manualStrobe (manualStrobe),
    .trigMode     (trigMode),
    .repeatCount  (repeatCount),
    .strobes      (strobes)
  );

  gins_datapath dp_i (
    .srcClk      (srcClk),
    .glitchPulse (glitchPulse),
    .glitchType  (glitchType),
    .strobes     (strobes),
    .glitchClk   (glitchClk)
  );

  assign busy = strobes.glitchOn;

endmodule

// File: rtl/gins_checker.sv
module gins_checker (
  input logic       srcClk,
  input logic       rstN,
  input logic       capTrig,
  input logic       manualStrobe,
  input logic [1:0] trigMode,
  input logic [2:0] glitchType,
  input logic       busy,
  input logic       glitchClk
);

  logic capSeen;
  logic stbSeen;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      capSeen <= 1'b0;
      stbSeen <= 1'b0;
    end else begin
      capSeen <= capTrig;
      stbSeen <= manualStrobe;
    end
  end

  p_manual_start_r2: assert property (@(posedge srcClk) disable iff (!rstN)
    (trigMode == 2'b00 && manualStrobe && !stbSeen) |=> busy);

  p_held_capture_r4: assert property (@(posedge srcClk) disable iff (!rstN)
    (trigMode == 2'b01 && capTrig && capSeen && !busy) |=> !busy);

  p_free_run_r6: assert property (@(posedge srcClk) disable iff (!rstN)
    (trigMode == 2'b10) |=> busy);

  p_idle_clock_r7: assert property (@(negedge srcClk) disable iff (!rstN)
    (!busy && glitchType <= 3'b010) |-> (glitchClk == srcClk));

  p_level_pulse_r8: assert property (@(negedge srcClk) disable iff (!rstN)
    (glitchType == 3'b100) |-> (glitchClk == busy));

endmodule

bind gins_top gins_checker chk_i (
  .srcClk       (srcClk),
  .rstN         (rstN),
  .capTrig      (capTrig),
  .manualStrobe (manualStrobe),
  .trigMode     (trigMode),
  .glitchType   (glitchType),
  .busy         (busy),
  .glitchClk    (glitchClk)
);

// File: tb/gins_top_tb_top.sv
module gins_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             capTrig = 1'b0;
  logic             glitchPulse = 1'b0;
  logic [1:0]       trigMode = 2'b00;
  logic [2:0]       glitchType = 3'b000;
  logic             manualStrobe = 1'b0;
  logic [CNT_W-1:0] repeatCount = '0;
  logic             glitchClk;
  logic             busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  bit mPrevCap, mPrevStb, mArmed, mActive;
  int mCnt;

  // burst statistics seen at the ports
  int curRun = 0;
  int lastRun = 0;
  int runs = 0;

  gins_top #(.CNT_W(CNT_W)) dut_i (
    .srcClk(clk), .rstN(rstN), .capTrig(capTrig), .glitchPulse(glitchPulse),
    .trigMode(trigMode), .glitchType(glitchType), .manualStrobe(manualStrobe),
    .repeatCount(repeatCount), .glitchClk(glitchClk), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit expClk(input bit [2:0] t, input bit c, input bit g, input bit a);
    case (t)
      3'b000: return a ? (c ^ g) : c;
      3'b001: return a ? (c | g) : c;
      3'b010: return a ? g : c;
      3'b100: return a;
      default: return c;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareNow();
    string tag;
    tag = (glitchType <= 3'b010) ? "R7" : "R8";
    check("R3 busy vs model", busy, mActive);
    check(tag, glitchClk, expClk(glitchType, clk, glitchPulse, mActive));
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPrevCap = 0; mPrevStb = 0; mArmed = 0; mActive = 0; mCnt = 0;
    end else begin
      bit capUp, stbUp, fire;
      capUp = capTrig && !mPrevCap;
      stbUp = manualStrobe && !mPrevStb;
      case (trigMode)
        2'b00: fire = stbUp;
        2'b01: fire = capUp;
        2'b11: fire = capUp && mArmed && manualStrobe;
        default: fire = 0;
      endcase
      if (fire) begin mActive = 1; mCnt = 0; end
      else if (trigMode == 2'b10) mActive = 1;
      else if (mActive) begin
        if (mCnt >= int'(repeatCount)) mActive = 0;
        else mCnt++;
      end
      if (stbUp) mArmed = 1;
      else if (!manualStrobe || (trigMode == 2'b11 && fire)) mArmed = 0;
      mPrevCap = capTrig;
      mPrevStb = manualStrobe;
    end
    #1;
    if (!finished) begin
      compareNow();
      if (busy) curRun++;
      else if (curRun > 0) begin lastRun = curRun; runs++; curRun = 0; end
    end
  end

  always @(negedge clk) begin
    glitchPulse <= 1'($urandom % 2);
    #1;
    if (!finished) compareNow();
  end

  task automatic clearStats();
    curRun = 0; lastRun = 0; runs = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobePulse();
    @(negedge clk) manualStrobe = 1'b1;
    @(negedge clk) manualStrobe = 1'b0;
  endtask

  task automatic capPulse();
    @(negedge clk) capTrig = 1'b1;
    @(negedge clk) capTrig = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    idle(3);
    #1;
    check("R1 busy in reset", busy, 0);
    check("R1 clock low phase", glitchClk, clk);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk) #2;
    check("R1 busy after reset", busy, 0);
    check("R1 clock high phase", glitchClk, 1);
    idle(2);

    // R2 / R3 manual mode, single cycle
    clearStats();
    repeatCount = 0;
    strobePulse();
    idle(10);
    check("R3 repeat 0 length", lastRun, 1);
    check("R2 manual burst count", runs, 1);

    // R2 held strobe gives one burst
    clearStats();
    repeatCount = 5;
    @(negedge clk) manualStrobe = 1'b1;
    idle(30);
    @(negedge clk) manualStrobe = 1'b0;
    idle(5);
    check("R2 held strobe bursts", runs, 1);
    check("R3 repeat 5 length", lastRun, 6);

    // R3 beyond one byte, XOR type
    clearStats();
    repeatCount = 300;
    strobePulse();
    idle(320);
    check("R3 repeat 300 length", lastRun, 301);

    // R10 capture ignored in manual mode
    clearStats();
    repeatCount = 3;
    capPulse();
    idle(10);
    check("R10 capture in manual", runs, 0);

    // R4 capture mode
    trigMode = 2'b01;
    glitchType = 3'b001;
    clearStats();
    capPulse();
    idle(10);
    check("R4 capture burst length", lastRun, 4);
    clearStats();
    @(negedge clk) capTrig = 1'b1;
    idle(40);
    @(negedge clk) capTrig = 1'b0;
    idle(5);
    check("R4 held capture bursts", runs, 1);

    // R10 strobe ignored in capture mode
    clearStats();
    strobePulse();
    idle(10);
    check("R10 strobe in capture", runs, 0);

    // R9 retrigger restarts the count
    clearStats();
    repeatCount = 10;
    @(negedge clk) capTrig = 1'b1;
    @(negedge clk) capTrig = 1'b0;
    idle(2);
    @(negedge clk) capTrig = 1'b1;
    @(negedge clk) capTrig = 1'b0;
    idle(20);
    check("R9 retrigger length", lastRun, 15);
    check("R9 retrigger bursts", runs, 1);

    // R5 single shot
    trigMode = 2'b11;
    glitchType = 3'b010;
    repeatCount = 2;
    clearStats();
    capPulse();
    idle(8);
    check("R5 unarmed capture", runs, 0);
    @(negedge clk) manualStrobe = 1'b1;
    idle(2);
    capPulse();
    idle(8);
    check("R5 armed burst", runs, 1);
    check("R5 armed length", lastRun, 3);
    capPulse();
    idle(8);
    check("R5 spent arm", runs, 1);
    @(negedge clk) manualStrobe = 1'b0;
    idle(2);
    @(negedge clk) manualStrobe = 1'b1;
    idle(2);
    capPulse();
    idle(8);
    check("R5 rearmed burst", runs, 2);
    @(negedge clk) manualStrobe = 1'b0;
    idle(2);

    // R6 continuous
    trigMode = 2'b10;
    repeatCount = 0;
    glitchType = 3'b000;
    clearStats();
    idle(60);
    check("R6 continuous run", (curRun >= 58) ? 1 : 0, 1);
    @(negedge clk) trigMode = 2'b00;
    idle(10);
    check("R6 leaves continuous", busy, 0);

    // R8 level type idle and busy, clock-only type in a burst
    glitchType = 3'b100;
    @(negedge clk) #1;
    check("R8 level idle low phase", glitchClk, 0);
    @(posedge clk) #2;
    check("R8 level idle high phase", glitchClk, 0);
    repeatCount = 20;
    strobePulse();
    @(negedge clk) #1;
    check("R8 level busy", glitchClk, 1);
    glitchType = 3'b011;
    @(negedge clk) begin glitchPulse = 1'b1; end
    #1;
    check("R8 clock only in burst", glitchClk, clk);
    idle(25);
    for (int t = 5; t < 8; t++) begin
      glitchType = 3'(t);
      strobePulse();
      idle(25);
    end

    // R7 types in bursts with random pulse (compared each half cycle)
    for (int t = 0; t < 3; t++) begin
      glitchType = 3'(t);
      repeatCount = 7;
      strobePulse();
      idle(15);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule